// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one IEEE-754 operand per clock, as a raw bit pattern in either binary32 or binary64 format, and returns the same-format value rounded to an integral value under one of four rounding directions. It sits beside a floating-point register file: the operand, a precision bit and a 2-bit direction code are presented with a valid strobe, and the rounded bit pattern appears one clock later with its own valid flag. There is no backpressure; a new operand can be accepted every cycle.

The rounding is done in the magnitude domain. The fractional bits below the binary point are masked off, a per-direction decision chooses whether to add one unit in the last integral place, and a carry out of the significand moves the exponent up by one. The operand's sign is always kept, so small negative values that round to zero give negative zero. The interval that collapses to negative zero differs between the two tie-breaking directions: with ties-to-even it includes -0.5, with ties-away it does not. Infinities, zeros and operands whose exponent already places the binary point past the last fraction bit go through unchanged; NaNs bypass rounding and leave quiet.

Top module: `fpri_unit`

## Requirements
- R1: Latency is exactly one clock: `out_valid` in a cycle equals `in_valid` of the previous cycle, and `out_res` loads only when `in_valid` is high. During reset `out_valid` and `out_res` are 0.
- R2: `in_dbl`=1 selects binary64 over all 64 bits; `in_dbl`=0 selects binary32 in `in_op[31:0]`, ignores `in_op[63:32]` and returns zeros in `out_res[63:32]`.
- R3: The direction code `in_mode` is 0 = ties-to-even, 1 = toward minus infinity, 2 = toward zero, 3 = ties-away-from-zero (e.g. 2.5 gives 2, 2, 2, 3; -2.5 gives -2, -3, -2, -3).
- R4: Ties-to-even: a fraction above one half rounds the magnitude up, exactly one half rounds to the even neighbour, and every input in [-0.5, 0) yields negative zero.
- R5: Ties-away: a fraction of one half or more rounds the magnitude up; inputs in (-0.5, 0) yield negative zero while -0.5 yields -1.
- R6: Toward zero: the fraction is discarded (floor for positive, ceiling for negative inputs), so inputs in (-1, 0) yield negative zero.
- R7: Toward minus infinity: the result is the floor; positive inputs below 1 yield +0 and negative inputs in (-1, 0), subnormals included, yield -1.
- R8: Positive and negative infinity are returned bit-identical.
- R9: A NaN (exponent all ones, fraction non-zero) is returned with the top fraction bit set (bit 51 for binary64, bit 22 for binary32) and its sign and other payload bits kept; a quiet NaN is thus unchanged.
- R10: Zeros of either sign and operands with unbiased exponent at or above the fraction width (52 or 23) are returned bit-identical.
- R11: For every non-NaN operand the result carries the operand's sign bit (bit 63 or bit 31).
- R12: When rounding up carries out of the significand, the result is the next power of two: exponent plus one and fraction zero (e.g. 1.5 under ties-to-even gives 2.0, values just below 1 give 1.0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_dbl | input | 1 | 1 = binary64, 0 = binary32 in the low half |
| in_mode | input | 2 | Rounding direction code (see R3) |
| in_op | input | 64 | Operand bit pattern |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 64 | Rounded result bit pattern |

## Verification
Because the unit holds no state beyond its output register, any internal fault shows at the ports in the very next cycle after the operand that triggers it. A wrong round-up decision shows as a result one unit away from the expected integer, a lost carry shows as a fraction of all zeros with an unchanged exponent (a value halved), and a wrong sign path shows as a positive zero where negative zero is due. The bench therefore compares every result one clock after it is presented, against a model that works on real-number values rather than on bit fields, with directed ties at ±0.5, ±1.5 and ±2.5 in both formats and every direction.

// File: rtl/fpri_pkg.sv
`timescale 1ns/1ps
package fpri_pkg;

  localparam int XLEN     = 64;
  localparam int SP_EXPW  = 8;
  localparam int SP_FRACW = 23;
  localparam int DP_EXPW  = 11;
  localparam int DP_FRACW = 52;
  localparam int NUM_FMT  = 2;

  typedef enum logic [1:0] {
    RD_EVEN  = 2'd0,
    RD_DOWN  = 2'd1,
    RD_TRUNC = 2'd2,
    RD_AWAY  = 2'd3
  } rdir_e;

  // Decide whether the magnitude's integral part gains one unit.
  function automatic logic need_bump(input rdir_e dir, input logic neg,
                                     input logic int_odd, input logic above_half,
                                     input logic at_half, input logic any_frac);
    logic b;
    case (dir)
      RD_EVEN:  b = above_half | (at_half & int_odd);
      RD_DOWN:  b = neg & any_frac;
      RD_TRUNC: b = 1'b0;
      default:  b = above_half | at_half;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fpri_classify.sv
`timescale 1ns/1ps
module fpri_classify #(
  parameter int EXPW  = 8,
  parameter int FRACW = 23
) (
  input  logic [EXPW+FRACW:0] op_i,
  output logic                sign_o,
  output logic [EXPW-1:0]     exp_o,
  output logic [FRACW-1:0]    frac_o,
  output logic                is_zero_o,
  output logic                is_inf_o,
  output logic                is_nan_o,
  output logic                is_integral_o,
  output logic                is_tiny_o
);
  localparam int BIAS = (1 << (EXPW - 1)) - 1;
  localparam logic [EXPW:0] INT_EXP = (EXPW+1)'(BIAS + FRACW);

  logic exp_ones, exp_zero, frac_zero;

  assign sign_o = op_i[EXPW+FRACW];
  assign exp_o  = op_i[EXPW+FRACW-1:FRACW];
  assign frac_o = op_i[FRACW-1:0];

  assign exp_ones  = &exp_o;
  assign exp_zero  = ~|exp_o;
  assign frac_zero = ~|frac_o;

  assign is_zero_o     = exp_zero & frac_zero;
  assign is_inf_o      = exp_ones & frac_zero;
  assign is_nan_o      = exp_ones & ~frac_zero;
  assign is_integral_o = ~exp_ones & ({1'b0, exp_o} >= INT_EXP);
  assign is_tiny_o     = ~is_zero_o & ({1'b0, exp_o} < (EXPW+1)'(BIAS));
endmodule

// File: rtl/fpri_round_fmt.sv
`timescale 1ns/1ps
module fpri_round_fmt
  import fpri_pkg::*;
#(
  parameter int EXPW  = 8,
  parameter int FRACW = 23
) (
  input  logic [EXPW+FRACW:0] op_i,
  input  rdir_e               dir_i,
  output logic [EXPW+FRACW:0] res_o,
  output logic                ev_nan_o,
  output logic                ev_inf_o,
  output logic                ev_keep_o,
  output logic                ev_tiny_o,
  output logic                ev_bump_o,
  output logic                ev_carry_o
);
  localparam int BIAS = (1 << (EXPW - 1)) - 1;
  localparam int MW   = FRACW + 2;
  localparam int SHW  = $clog2(FRACW + 2) + 1;
  localparam logic [EXPW:0] SH_BASE = (EXPW+1)'(BIAS + FRACW);

  logic             sgn;
  logic [EXPW-1:0]  ex;
  logic [FRACW-1:0] fr;
  logic             c_zero, c_inf, c_nan, c_int, c_tiny;

  fpri_classify #(.EXPW(EXPW), .FRACW(FRACW)) u_cls (
    .op_i          (op_i),
    .sign_o        (sgn),
    .exp_o         (ex),
    .frac_o        (fr),
    .is_zero_o     (c_zero),
    .is_inf_o      (c_inf),
    .is_nan_o      (c_nan),
    .is_integral_o (c_int),
    .is_tiny_o     (c_tiny)
  );

  // Mid-range path: binary point inside the significand.
  logic [EXPW:0]  sh_full;
  logic [SHW-1:0] sh;
  logic [MW-1:0]  mant, unit, mask, half, fpart, ipart, summed;
  logic           mid_bump;

  assign sh_full  = SH_BASE - {1'b0, ex};
  assign sh       = sh_full[SHW-1:0];
  assign mant     = {1'b0, 1'b1, fr};
  assign unit     = MW'(1) << sh;
  assign mask     = unit - MW'(1);
  assign half     = unit >> 1;
  assign fpart    = mant & mask;
  assign ipart    = mant & ~mask;
  assign mid_bump = need_bump(dir_i, sgn, |(ipart & unit), fpart > half,
                              fpart == half, |fpart);
  assign summed   = ipart + (mid_bump ? unit : '0);

  // Tiny path: magnitude below one.
  logic half_exp, tiny_bump;
  assign half_exp  = (ex == EXPW'(BIAS - 1));
  assign tiny_bump = need_bump(dir_i, sgn, 1'b0, half_exp & (|fr),
                               half_exp & ~(|fr), 1'b1);

  logic [EXPW+FRACW:0] r;
  always_comb begin
    r = op_i;
    if (c_nan) begin
      r = {sgn, ex, 1'b1, fr[FRACW-2:0]};
    end else if (c_inf || c_zero || c_int) begin
      r = op_i;
    end else if (c_tiny) begin
      r = tiny_bump ? {sgn, EXPW'(BIAS), {FRACW{1'b0}}}
                    : {sgn, {EXPW{1'b0}}, {FRACW{1'b0}}};
    end else if (summed[MW-1]) begin
      r = {sgn, ex + EXPW'(1), {FRACW{1'b0}}};
    end else begin
      r = {sgn, ex, summed[FRACW-1:0]};
    end
  end

  assign res_o      = r;
  assign ev_nan_o   = c_nan;
  assign ev_inf_o   = c_inf;
  assign ev_keep_o  = c_zero | c_int;
  assign ev_tiny_o  = c_tiny;
  assign ev_bump_o  = ~c_nan & ~c_inf & ~c_zero & ~c_int & (c_tiny ? tiny_bump : mid_bump);
  assign ev_carry_o = ~c_nan & ~c_inf & ~c_zero & ~c_int &
                      (c_tiny ? tiny_bump : summed[MW-1]);
endmodule

// File: rtl/fpri_unit.sv
`timescale 1ns/1ps
module fpri_unit
  import fpri_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_dbl,
  input  logic [1:0]      in_mode,
  input  logic [XLEN-1:0] in_op,
  output logic            out_valid,
  output logic [XLEN-1:0] out_res
);
  rdir_e dir;
  assign dir = rdir_e'(in_mode);

  logic [XLEN-1:0]    fmt_res [NUM_FMT];
  logic [NUM_FMT-1:0] v_nan, v_inf, v_keep, v_tiny, v_bump, v_carry;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = (g == 0) ? SP_EXPW  : DP_EXPW;
    localparam int FW = (g == 0) ? SP_FRACW : DP_FRACW;
    localparam int W  = 1 + EW + FW;
    logic [W-1:0] r;
    fpri_round_fmt #(.EXPW(EW), .FRACW(FW)) u_rnd (
      .op_i       (in_op[W-1:0]),
      .dir_i      (dir),
      .res_o      (r),
      .ev_nan_o   (v_nan[g]),
      .ev_inf_o   (v_inf[g]),
      .ev_keep_o  (v_keep[g]),
      .ev_tiny_o  (v_tiny[g]),
      .ev_bump_o  (v_bump[g]),
      .ev_carry_o (v_carry[g])
    );
    assign fmt_res[g] = XLEN'(r);
  end

  // Named events of the selected format, observed by the checker.
  logic nan_evt, inf_evt, keep_evt, tiny_evt, bump_evt, carry_evt;
  assign nan_evt   = v_nan[in_dbl];
  assign inf_evt   = v_inf[in_dbl];
  assign keep_evt  = v_keep[in_dbl];
  assign tiny_evt  = v_tiny[in_dbl];
  assign bump_evt  = v_bump[in_dbl];
  assign carry_evt = v_carry[in_dbl];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_res <= fmt_res[in_dbl];
    end
  end
endmodule

// File: rtl/fpri_unit_chk.sv
`timescale 1ns/1ps
module fpri_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_dbl,
  input logic [63:0] in_op,
  input logic        out_valid,
  input logic [63:0] out_res,
  input logic        nan_evt,
  input logic        inf_evt,
  input logic        keep_evt,
  input logic        tiny_evt,
  input logic        bump_evt,
  input logic        carry_evt
);
  logic [63:0] op_eff, qbit;
  logic        sign_in;
  assign op_eff  = in_dbl ? in_op : {32'h0, in_op[31:0]};
  assign qbit    = in_dbl ? 64'h0008_0000_0000_0000 : 64'h0000_0000_0040_0000;
  assign sign_in = in_dbl ? in_op[63] : in_op[31];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_res))); // R1
  AST_SP_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dbl) |=> (out_res[63:32] == 32'h0)); // R2
  AST_INF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inf_evt) |=> (out_res == $past(op_eff))); // R8
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_evt) |=> (out_res == ($past(op_eff) | $past(qbit)))); // R9
  AST_KEEP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && keep_evt) |=> (out_res == $past(op_eff))); // R10
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_evt) |=>
      (($past(in_dbl) ? out_res[63] : out_res[31]) == $past(sign_in))); // R11
  AST_CARRY_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_evt) |=>
      ($past(in_dbl) ? (out_res[51:0] == 52'h0) : (out_res[22:0] == 23'h0))); // R12
  AST_TINY_NO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({nan_evt, inf_evt, keep_evt, tiny_evt})); // R10
  AST_CARRY_NEEDS_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_evt) |-> bump_evt); // R12
endmodule

bind fpri_unit fpri_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_dbl    (in_dbl),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_res   (out_res),
  .nan_evt   (nan_evt),
  .inf_evt   (inf_evt),
  .keep_evt  (keep_evt),
  .tiny_evt  (tiny_evt),
  .bump_evt  (bump_evt),
  .carry_evt (carry_evt)
);

// File: tb/fpri_unit_tb.sv
`timescale 1ns/1ps
module fpri_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_dbl = 1'b0;
  logic [1:0]  in_mode = 2'd0;
  logic [63:0] in_op = 64'h0;
  logic        out_valid;
  logic [63:0] out_res;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpri_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
    .in_mode(in_mode), .in_op(in_op), .out_valid(out_valid), .out_res(out_res)
  );

  // ---------------- reference model on real values ----------------
  function automatic real pow2(input int e);
    real p = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) p = p * 2.0;
    else        for (int i = 0; i < -e; i++) p = p / 2.0;
    return p;
  endfunction

  function automatic real round_real(input real x, input int mode);
    real fl = $floor(x);
    real er = x - fl;
    real h;
    case (mode)
      0: begin
        h = fl / 2.0;
        if (er > 0.5 || (er == 0.5 && h != $floor(h))) fl = fl + 1.0;
      end
      1: ;
      2: if (x < 0.0) fl = $ceil(x);
      default: if (er > 0.5 || (er == 0.5 && fl >= 0.0)) fl = fl + 1.0;
    endcase
    return fl;
  endfunction

  function automatic logic [63:0] ref_dp(input logic [63:0] b, input int mode);
    logic [63:0] o;
    if (b[62:52] == 11'h7FF) return (b[51:0] == 0) ? b : (b | 64'h0008_0000_0000_0000);
    o = $realtobits(round_real($bitstoreal(b), mode));
    o[63] = b[63];
    return o;
  endfunction

  function automatic logic [31:0] ref_sp(input logic [31:0] b, input int mode);
    real x;
    logic [63:0] d;
    logic [10:0] de;
    if (b[30:23] == 8'hFF) return (b[22:0] == 0) ? b : (b | 32'h0040_0000);
    if (b[30:23] == 0) x = $itor(b[22:0]) * pow2(-149);
    else x = (1.0 + $itor(b[22:0]) * pow2(-23)) * pow2(int'(b[30:23]) - 127);
    if (b[31]) x = -x;
    d = $realtobits(round_real(x, mode));
    if (d[62:0] == 63'h0) return {b[31], 31'h0};
    de = d[62:52] - 11'd896;
    return {b[31], de[7:0], d[51:29]};
  endfunction

  function automatic string tag_of(input int mode);
    case (mode)
      0: return "R3 R4";
      1: return "R3 R7";
      2: return "R3 R6";
      default: return "R3 R5";
    endcase
  endfunction

  // ---------------- check helpers ----------------
  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: presents one operand, checks it one edge later.
  task automatic run_op(input string tag, input logic dbl, input int mode,
                        input logic [63:0] op, input logic [63:0] exp);
    in_valid = 1'b1;
    in_dbl   = dbl;
    in_mode  = mode[1:0];
    in_op    = op;
    @(negedge clk);
    check({tag, " R1 valid"}, {63'h0, out_valid}, 64'h1);
    check(tag, out_res, exp);
  endtask

  task automatic run_ref(input string tag, input logic dbl, input int mode, input logic [63:0] op);
    logic [63:0] e = dbl ? ref_dp(op, mode) : {32'h0, ref_sp(op[31:0], mode)};
    run_op(tag, dbl, mode, op, e);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    #1;
    check("R1 reset valid", {63'h0, out_valid}, 64'h0);
    check("R1 reset result", out_res, 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: 2.5 and -2.5 in every direction, binary64, fixed expectations
    run_op("R3 R4", 1, 0, 64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000);
    run_op("R3 R7", 1, 1, 64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000);
    run_op("R3 R6", 1, 2, 64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000);
    run_op("R3 R5", 1, 3, 64'h4004_0000_0000_0000, 64'h4008_0000_0000_0000);
    run_op("R3 R4", 1, 0, 64'hC004_0000_0000_0000, 64'hC000_0000_0000_0000);
    run_op("R3 R7", 1, 1, 64'hC004_0000_0000_0000, 64'hC008_0000_0000_0000);
    run_op("R3 R6", 1, 2, 64'hC004_0000_0000_0000, 64'hC000_0000_0000_0000);
    run_op("R3 R5", 1, 3, 64'hC004_0000_0000_0000, 64'hC008_0000_0000_0000);

    // Ties at +-0.5, +-1.5, +-2.5 in both formats and all directions
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        run_ref(tag_of(m), 1, m, {s[0], 63'h3FE0_0000_0000_0000});
        run_ref(tag_of(m), 1, m, {s[0], 63'h3FF8_0000_0000_0000});
        run_ref(tag_of(m), 1, m, {s[0], 63'h4004_0000_0000_0000});
        run_ref(tag_of(m), 0, m, {32'hDEAD_BEEF, s[0], 31'h3F00_0000});
        run_ref(tag_of(m), 0, m, {32'h0, s[0], 31'h3FC0_0000});
        run_ref(tag_of(m), 0, m, {32'h1234_5678, s[0], 31'h4020_0000});
      end
    end

    // Negative-zero interval edges
    run_op("R4 -0.5 to -0", 1, 0, 64'hBFE0_0000_0000_0000, 64'h8000_0000_0000_0000);
    run_op("R5 -0.5 to -1", 1, 3, 64'hBFE0_0000_0000_0000, 64'hBFF0_0000_0000_0000);
    run_op("R5 -0.3 to -0", 0, 3, 64'h0000_0000_BE99_999A, 64'h0000_0000_8000_0000);
    run_op("R6 -0.7 to -0", 1, 2, 64'hBFE6_6666_6666_6666, 64'h8000_0000_0000_0000);
    run_op("R7 +0.3 to +0", 1, 1, 64'h3FD3_3333_3333_3333, 64'h0000_0000_0000_0000);
    run_op("R7 subnormal", 1, 1, 64'h8000_0000_0000_0001, 64'hBFF0_0000_0000_0000);
    run_op("R7 -0.3 to -1", 0, 1, 64'h0000_0000_BE99_999A, 64'h0000_0000_BF80_0000);

    // Specials
    run_op("R8 +inf", 1, 3, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000);
    run_op("R8 -inf", 0, 1, 64'hAAAA_AAAA_FF80_0000, 64'h0000_0000_FF80_0000);
    run_op("R9 snan dp", 1, 0, 64'hFFF0_0000_0000_0001, 64'hFFF8_0000_0000_0001);
    run_op("R9 qnan dp", 1, 2, 64'h7FF8_0000_0000_00A5, 64'h7FF8_0000_0000_00A5);
    run_op("R9 snan sp", 0, 1, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0001);
    run_op("R10 +0", 1, 1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000);
    run_op("R10 -0", 1, 3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    run_op("R10 big dp", 1, 1, 64'hC330_0000_0000_0001, 64'hC330_0000_0000_0001);
    run_op("R10 big sp", 0, 0, 64'h0000_0000_CB00_0001, 64'h0000_0000_CB00_0001);

    // Carry into the exponent
    run_op("R12 0.75 even", 1, 0, 64'h3FE8_0000_0000_0000, 64'h3FF0_0000_0000_0000);
    run_op("R12 1.5 even", 1, 0, 64'h3FF8_0000_0000_0000, 64'h4000_0000_0000_0000);
    run_op("R12 3.5 even", 0, 0, 64'h0000_0000_4060_0000, 64'h0000_0000_4080_0000);
    run_op("R12 under 1 away", 0, 3, 64'h0000_0000_3F7F_FFFF, 64'h0000_0000_3F80_0000);
    run_op("R12 -1.75 down", 1, 1, 64'hBFFC_0000_0000_0000, 64'hC000_0000_0000_0000);

    // R2: binary32 with garbage in the upper half equals the clean result
    run_op("R2 upper ignored", 0, 3, 64'hFFFF_FFFF_4020_0000, 64'h0000_0000_4040_0000);

    // R1: idle cycle holds the result and drops valid
    held = out_res;
    in_valid = 1'b0;
    in_op = 64'h4004_0000_0000_0000;
    in_dbl = 1'b1;
    @(negedge clk);
    check("R1 idle valid", {63'h0, out_valid}, 64'h0);
    check("R1 idle hold", out_res, held);

    // Constrained random
    for (int k = 0; k < 4000; k++) begin
      logic dbl;
      int mode;
      logic [63:0] op;
      logic [63:0] e;
      logic [51:0] fr;
      int cut;
      dbl  = $urandom_range(0, 1) != 0;
      mode = int'($urandom_range(0, 3));
      op   = {$urandom, $urandom};
      cut  = int'($urandom_range(0, 52));
      fr   = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) fr = fr & ~((52'h1 << cut) - 52'h1);
      if ($urandom_range(0, 7) != 0) begin
        if (dbl) op = {op[63], 11'(1023 - 3 + $urandom_range(0, 57)), fr};
        else     op = {op[63:32], op[31], 8'(127 - 3 + $urandom_range(0, 28)), fr[51:29]};
      end
      e = dbl ? ref_dp(op, mode) : {32'h0, ref_sp(op[31:0], mode)};
      in_valid = 1'b1;
      in_dbl   = dbl;
      in_mode  = mode[1:0];
      in_op    = op;
      @(negedge clk);
      check(tag_of(mode), out_res, e);
      if (!((dbl && op[62:52] == 11'h7FF && op[51:0] != 0) ||
            (!dbl && op[30:23] == 8'hFF && op[22:0] != 0)))
        check("R11 sign", {63'h0, dbl ? out_res[63] : out_res[31]},
              {63'h0, dbl ? op[63] : op[31]});
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule